// File: doc/BRIEF.md
# CPU Clock Source Selector

This block picks the rate at which the processor core advances. It chooses between the main oscillator and a slow subsystem oscillator, and it can divide or multiply either one. Both oscillators run outside the block. Each arrives as a one-cycle tick on the block's system clock. The external ×4 multiplier arrives the same way, as its own tick input.

The block's output is a single-cycle enable, `cpuTick`. The core advances on a system clock edge only when `cpuTick` is high. Because the output is an enable and not a gated clock, a change of source cannot produce a runt pulse.

Software controls the block through one 8-bit control register on a simple bus. The register holds two bits:
- a divide-select bit (bit 1), which picks the main clock undivided or divided by four;
- a main oscillator stop bit (bit 7), which drives the oscillator enable.

Three inputs come from registers that are not part of this block: the subclock flag, the multiplier enable, and the ×4 tick. The subclock flag decides whether the main or the subsystem path feeds the core. The stop bit is protected: it can be set only while the subsystem path is feeding the core.

Top module: `cpu_clk_sel`

## Requirements
- R1: After reset, a read at address 0xFFFB returns 0x02, and `mainOscEn` is 1.
- R2: A read at any other address returns 0x00. A write at any other address leaves the register unchanged.
- R3: A byte write (`wrEn`) stores bit 7 (stop) and bit 1 (divide-select). Bits 0 and 2 to 6 always read back 0.
- R4: A single-bit write (`bitWrEn`) with index 7 or 1 changes only that bit. Any other index changes nothing. If `wrEn` and `bitWrEn` are high in the same cycle, `wrEn` wins.
- R5: While `subSel` is 0, a write that would set the stop bit to 1 leaves it unchanged. In a byte write, the divide-select bit is still stored.
- R6: `mainOscEn` is the inverse of the stop bit. The stop bit can be set while `subSel` is 1, and it can be cleared at any time.
- R7: With `subSel`=0 and divide-select=0, `cpuTick` equals `mainTick` gated by `mainOscEn`.
- R8: With `subSel`=0 and divide-select=1, `cpuTick` gives exactly one pulse per four `mainTick` pulses. Each `cpuTick` pulse coincides with a `mainTick` pulse.
- R9: With `subSel`=1 and `mulEn`=0, `cpuTick` gives one pulse per two `subTick` pulses. Each `cpuTick` pulse coincides with a `subTick` pulse.
- R10: With `subSel`=1 and `mulEn`=1, `cpuTick` equals `subX4Tick`. The divide-select bit has no effect while `subSel` is 1.
- R11: `cpuTick` is never high in a cycle in which none of `mainTick`, `subTick` and `subX4Tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| wrData | input | 8 | Byte write data |
| wrEn | input | 1 | Byte write strobe |
| bitWrEn | input | 1 | Single-bit write strobe |
| bitIdx | input | 3 | Bit index for a single-bit write |
| bitVal | input | 1 | Bit value for a single-bit write |
| rdData | output | 8 | Register read data (0 when the address misses) |
| subSel | input | 1 | Subclock flag from the companion register |
| mulEn | input | 1 | Selects subsystem ×4 instead of subsystem /2 |
| mainTick | input | 1 | Main oscillator tick |
| subTick | input | 1 | Subsystem oscillator tick |
| subX4Tick | input | 1 | Tick from the external ×4 multiplier |
| cpuTick | output | 1 | CPU clock enable pulse |
| mainOscEn | output | 1 | Main oscillator run enable |

## Verification
Each of the four modes is driven with a continuous run of sixteen ticks. The pulse count then separates undivided (16), divide-by-four (4) and divide-by-two (8), whatever phase the divider counters start from. A second pattern asserts the tick only on alternate cycles and counts any `cpuTick` seen in the idle cycles. This separates a correctly qualified enable from one that is held or leaks. In the ×4 mode, the ×4 tick and the subsystem tick are driven on different cycles, so a wrong mux leg shows up as a count mismatch. The protection rule is tried by byte write and by bit write, with the subclock flag both low and high, and each result is read back over the bus.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  // Selection strobes from control to datapath
  typedef struct packed {
    logic mainRun;   // main oscillator allowed to run
    logic divMain;   // main path divided by four
    logic useSub;    // subsystem path feeds the core
    logic useMul;    // subsystem x4 instead of /2
  } sel_t;
endpackage

// File: rtl/ccs_tick_div.sv
module ccs_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickIn,
  output logic tickOut
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (tickIn)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tickOut = tickIn && (cnt == LAST);
endmodule

// File: rtl/ccs_ctrl.sv
module ccs_ctrl
  import ccs_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] REG_ADDR  = 16'hFFFB,
  parameter int          STOP_BIT  = 7,
  parameter int          DIV_BIT   = 1,
  parameter logic [7:0]  RESET_VAL = 8'h02,
  localparam int         IDX_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              bitWrEn,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              bitVal,
  input  logic              subSel,
  input  logic              mulEn,
  output logic [DATA_W-1:0] rdData,
  output sel_t              sel
);
  logic hit;
  logic stopQ, divQ, stopNext, divNext;
  logic [DATA_W-1:0] image;

  assign hit = (addr == ADDR_W'(REG_ADDR));

  always_comb begin
    stopNext = stopQ;
    divNext  = divQ;
    if (wrEn && hit) begin
      stopNext = wrData[STOP_BIT];
      divNext  = wrData[DIV_BIT];
    end else if (bitWrEn && hit) begin
      if (bitIdx == IDX_W'(STOP_BIT))     stopNext = bitVal;
      else if (bitIdx == IDX_W'(DIV_BIT)) divNext  = bitVal;
    end
    // stop may only be raised while the subsystem path drives the core
    if (!subSel && stopNext) stopNext = stopQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopQ <= RESET_VAL[STOP_BIT];
      divQ  <= RESET_VAL[DIV_BIT];
    end else begin
      stopQ <= stopNext;
      divQ  <= divNext;
    end
  end

  always_comb begin
    image           = '0;
    image[STOP_BIT] = stopQ;
    image[DIV_BIT]  = divQ;
  end

  assign rdData      = hit ? image : '0;
  assign sel.mainRun = !stopQ;
  assign sel.divMain = divQ;
  assign sel.useSub  = subSel;
  assign sel.useMul  = mulEn;
endmodule

// File: rtl/ccs_datapath.sv
module ccs_datapath
  import ccs_pkg::*;
#(
  parameter int MAIN_DIV = 4,
  parameter int SUB_DIV  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  sel_t sel,
  input  logic mainTick,
  input  logic subTick,
  input  logic subX4Tick,
  output logic cpuTick
);
  logic mainLive, mainSlow, subSlow;

  assign mainLive = mainTick && sel.mainRun;

  ccs_tick_div #(.DIV(MAIN_DIV)) i_mainDiv (
    .clk(clk), .rstN(rstN), .tickIn(mainLive), .tickOut(mainSlow));

  ccs_tick_div #(.DIV(SUB_DIV)) i_subDiv (
    .clk(clk), .rstN(rstN), .tickIn(subTick), .tickOut(subSlow));

  always_comb begin
    unique case ({sel.useSub, sel.useMul, sel.divMain})
      3'b000, 3'b010: cpuTick = mainLive;
      3'b001, 3'b011: cpuTick = mainSlow;
      3'b100, 3'b101: cpuTick = subSlow;
      default:        cpuTick = subX4Tick;
    endcase
  end
endmodule

// File: rtl/cpu_clk_sel.sv
module cpu_clk_sel
  import ccs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  input  logic        wrEn,
  input  logic        bitWrEn,
  input  logic [2:0]  bitIdx,
  input  logic        bitVal,
  output logic [7:0]  rdData,
  input  logic        subSel,
  input  logic        mulEn,
  input  logic        mainTick,
  input  logic        subTick,
  input  logic        subX4Tick,
  output logic        cpuTick,
  output logic        mainOscEn
);
  sel_t sel;

  ccs_ctrl #(
    .ADDR_W(16), .DATA_W(8), .REG_ADDR(16'hFFFB),
    .STOP_BIT(7), .DIV_BIT(1), .RESET_VAL(8'h02)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .bitWrEn(bitWrEn), .bitIdx(bitIdx), .bitVal(bitVal), .subSel(subSel),
    .mulEn(mulEn), .rdData(rdData), .sel(sel));

  ccs_datapath #(.MAIN_DIV(4), .SUB_DIV(2)) i_dp (
    .clk(clk), .rstN(rstN), .sel(sel), .mainTick(mainTick),
    .subTick(subTick), .subX4Tick(subX4Tick), .cpuTick(cpuTick));

  assign mainOscEn = sel.mainRun;
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker
  import ccs_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [15:0] addr,
  input logic [7:0]  rdData,
  input logic        subSel,
  input logic        mulEn,
  input logic        mainTick,
  input logic        subTick,
  input logic        subX4Tick,
  input logic        cpuTick,
  input logic        mainOscEn,
  input sel_t        sel
);
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 16'hFFFB) |-> ((rdData & 8'h7D) == 8'h00));

  p_miss_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr != 16'hFFFB) |-> (rdData == 8'h00));

  p_stop_refused_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!subSel && mainOscEn) |=> mainOscEn);

  p_direct_main_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!subSel && !sel.divMain) |-> (cpuTick == (mainTick && mainOscEn)));

  p_x4_passthru_r10: assert property (@(posedge clk) disable iff (!rstN)
    (subSel && mulEn) |-> (cpuTick == subX4Tick));

  p_sub_half_r9: assert property (@(posedge clk) disable iff (!rstN)
    (subSel && !mulEn && cpuTick) |-> subTick);

  p_tick_sourced_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuTick |-> (mainTick || subTick || subX4Tick));
endmodule

bind cpu_clk_sel ccs_checker i_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdData(rdData), .subSel(subSel),
  .mulEn(mulEn), .mainTick(mainTick), .subTick(subTick),
  .subX4Tick(subX4Tick), .cpuTick(cpuTick), .mainOscEn(mainOscEn), .sel(sel));

// File: tb/test_cpu_clk_sel.sv
`timescale 1ns/1ps
module test_cpu_clk_sel;
  localparam logic [15:0] REG = 16'hFFFB;

  logic clk = 0, rstN = 0;
  logic [15:0] addr = REG;
  logic [7:0]  wrData = 0, rdData;
  logic        wrEn = 0, bitWrEn = 0, bitVal = 0;
  logic [2:0]  bitIdx = 0;
  logic        subSel = 0, mulEn = 0, mainTick = 0, subTick = 0, subX4Tick = 0;
  logic        cpuTick, mainOscEn;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  cpu_clk_sel i_cpu_clk_sel (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .bitWrEn(bitWrEn), .bitIdx(bitIdx), .bitVal(bitVal), .rdData(rdData),
    .subSel(subSel), .mulEn(mulEn), .mainTick(mainTick), .subTick(subTick),
    .subX4Tick(subX4Tick), .cpuTick(cpuTick), .mainOscEn(mainOscEn));

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic byteWr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0; addr = REG;
  endtask

  task automatic bitWr(logic [2:0] idx, logic v);
    @(negedge clk); bitIdx = idx; bitVal = v; bitWrEn = 1;
    @(negedge clk); bitWrEn = 0;
  endtask

  task automatic readReg(logic [15:0] a, output int v);
    @(negedge clk); addr = a; #1 v = rdData; addr = REG;
  endtask

  // Drive n cycles of a tick pattern; count pulses, and pulses in idle cycles
  task automatic runTicks(int which, int n, bit sparse, output int pulses, output int stray);
    pulses = 0; stray = 0;
    for (int i = 0; i < n * (sparse ? 2 : 1); i++) begin
      @(negedge clk);
      begin
        logic on;
        on = !sparse || (i % 2 == 0);
        mainTick  = (which == 0) && on;
        subTick   = (which == 1) && on;
        subX4Tick = (which == 2) && on;
        #1;
        if (cpuTick) begin
          if (on) pulses++; else stray++;
        end
      end
    end
    @(negedge clk); mainTick = 0; subTick = 0; subX4Tick = 0;
  endtask

  task automatic t_reset();
    int v;
    readReg(REG, v);
    check("R1 reset value", v, 8'h02);
    check("R1 oscillator enabled", mainOscEn, 1);
  endtask

  task automatic t_decode();
    int v;
    readReg(16'hFFFA, v);
    check("R2 miss read", v, 0);
    byteWr(16'hFFFC, 8'h00);
    readReg(REG, v);
    check("R2 miss write ignored", v, 8'h02);
  endtask

  task automatic t_byteWrite();
    int v;
    subSel = 1;
    byteWr(REG, 8'hFF);
    readReg(REG, v);
    check("R3 reserved bits read zero", v, 8'h82);
    byteWr(REG, 8'h00);
    readReg(REG, v);
    check("R3 byte clear", v, 8'h00);
    subSel = 0;
  endtask

  task automatic t_bitWrite();
    int v;
    bitWr(3'd1, 1);
    readReg(REG, v);
    check("R4 bit 1 set", v, 8'h02);
    bitWr(3'd3, 1);
    readReg(REG, v);
    check("R4 reserved index ignored", v, 8'h02);
    bitWr(3'd1, 0);
    readReg(REG, v);
    check("R4 bit 1 clear", v, 8'h00);
    @(negedge clk); addr = REG; wrData = 8'h02; wrEn = 1; bitWrEn = 1; bitIdx = 1; bitVal = 0;
    @(negedge clk); wrEn = 0; bitWrEn = 0;
    readReg(REG, v);
    check("R4 byte write wins", v, 8'h02);
  endtask

  task automatic t_protect();
    int v;
    subSel = 0;
    byteWr(REG, 8'h80);
    readReg(REG, v);
    check("R5 byte stop refused", v, 8'h00);
    check("R5 oscillator still on", mainOscEn, 1);
    byteWr(REG, 8'h82);
    readReg(REG, v);
    check("R5 divide bit still stored", v, 8'h02);
    bitWr(3'd7, 1);
    readReg(REG, v);
    check("R5 bit stop refused", v, 8'h02);
  endtask

  task automatic t_stop();
    int v;
    subSel = 1;
    bitWr(3'd7, 1);
    readReg(REG, v);
    check("R6 stop accepted on subclock", v, 8'h82);
    check("R6 oscillator off", mainOscEn, 0);
    byteWr(REG, 8'h02);
    check("R6 oscillator back on", mainOscEn, 1);
    subSel = 0;
  endtask

  task automatic t_direct();
    int p, s;
    subSel = 0; byteWr(REG, 8'h00);
    runTicks(0, 16, 0, p, s);
    check("R7 undivided count", p, 16);
    runTicks(0, 8, 1, p, s);
    check("R11 no stray pulse direct", s, 0);
  endtask

  task automatic t_div4();
    int p, s;
    subSel = 0; byteWr(REG, 8'h02);
    runTicks(0, 16, 0, p, s);
    check("R8 divide by four count", p, 4);
    runTicks(0, 8, 1, p, s);
    check("R8 sparse count", p, 2);
    check("R11 no stray pulse div4", s, 0);
  endtask

  task automatic t_sub2();
    int p, s;
    subSel = 1; mulEn = 0;
    runTicks(1, 16, 0, p, s);
    check("R9 subclock half count", p, 8);
    runTicks(1, 8, 1, p, s);
    check("R11 no stray pulse sub2", s, 0);
    runTicks(2, 8, 0, p, s);
    check("R9 x4 tick unused", p, 0);
  endtask

  task automatic t_x4();
    int p, s;
    subSel = 1; mulEn = 1;
    byteWr(REG, 8'h00);
    runTicks(2, 16, 0, p, s);
    check("R10 x4 pass count div0", p, 16);
    byteWr(REG, 8'h02);
    runTicks(2, 16, 0, p, s);
    check("R10 divide bit ignored", p, 16);
    runTicks(1, 8, 0, p, s);
    check("R10 sub tick unused", p, 0);
    runTicks(0, 8, 0, p, s);
    check("R11 main tick unused on sub", p, 0);
    subSel = 0; mulEn = 0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_decode();
    t_byteWrite();
    t_bitWrite();
    t_protect();
    t_stop();
    t_direct();
    t_div4();
    t_sub2();
    t_x4();
    report();
  end
endmodule